// File: doc/BRIEF.md
# Quad DAC Command Word Decoder

This block is the digital front end of a four-channel digital-to-analog converter. Each cycle it may accept one complete 16-bit command word. A two-bit mode field in the word sends it to one of three places. The first is a global system control register. The second is the control register of one addressed channel. The third is an input data register of one addressed channel. Each channel holds a 10-bit main converter and an 8-bit sub converter, and each of these has an input data register and a separate DAC register behind it.

The DAC registers are the only values that reach the output ports. A load strobe copies every channel's input data registers into its DAC registers in one cycle. An active-low clear input forces all DAC registers to a known code. That code depends on the input coding chosen in the system control register. The block comes out of reset in standby. A word that decodes to no valid target changes nothing and raises a one-cycle error pulse.

Top module: `dacdec_top`

## Requirements
- R1: The mode field `word_i[11:10]` selects the target of a word: 2'b00 is the system control register, 2'b01 is the control register of the addressed channel, and 2'b10 is a data register of the addressed channel.
- R2: In a data word, `word_i[15]` set to 0 selects the main converter and set to 1 selects the sub converter. `word_i[14:12]` is the channel address and `word_i[9:0]` is the data. A main write stores all 10 data bits.
- R3: A sub converter write stores the upper eight data bits `word_i[9:2]`.
- R4: After reset, the system control register has power-down (bit 0) = 1, system standby (bit 1) = 1 and coding (bit 2) = 0. Every channel control register reads 0. Every main DAC register reads 0x200 and every sub DAC register reads 0x80.
- R5: A system control word stores `word_i[2:0]` as {coding, standby, power-down}, whatever the address field holds. A coding bit of 1 means two's complement and 0 means offset binary. A channel control word stores `word_i[3:0]` in the control register of the addressed channel only.
- R6: The DAC registers change only on a load strobe, or on clear. A load copies the input data registers of all channels at once, using the values held before that cycle's write. The outputs show the new values one cycle after the strobe.
- R7: While `clear_n_i` is low, every main and sub DAC register is set to 0x200 and 0x80 under offset binary coding, or to 0x000 and 0x00 under two's complement coding. Clear takes priority over load and leaves the input data registers untouched.
- R8: A word with mode 2'b11, or a channel control or data word whose address is 4 or above, changes no register. It makes `err_o` high for exactly the one cycle after the word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Accept `word_i` this cycle |
| word_i | input | 16 | Command word |
| load_i | input | 1 | Load strobe: input data registers to DAC registers |
| clear_n_i | input | 1 | Active-low clear of all DAC registers |
| sys_ctrl_o | output | 3 | System control register {coding, standby, power-down} |
| chan_ctrl_o | output | 16 | Channel control registers, channel n at [4n+3:4n] |
| main_dac_o | output | 40 | Main DAC registers, channel n at [10n+9:10n] |
| sub_dac_o | output | 32 | Sub DAC registers, channel n at [8n+7:8n] |
| err_o | output | 1 | One-cycle pulse after an invalid word |

## Verification
The assertions assume that `clear_n_i` and `load_i` are clean synchronous levels. They also assume that the coding bit sampled in a clear cycle is the one that governs that cycle's clear value. The bench drives every input at the falling edge, so each level is steady across the next rising edge. It changes the coding only through complete system control words, and never in the same cycle as a clear. All 64 combinations of converter select, address and mode are swept. Data values are stepped across the full 10-bit range on every channel.

// File: rtl/dacdec_pkg.sv
package dacdec_pkg;
  localparam int WORD_W = 16;
  localparam int DATA_W = 10;
  localparam int ADDR_W = 3;

  localparam int SEL_BIT = 15;
  localparam int ADDR_LSB = 12;
  localparam int MODE_LSB = 10;

  typedef enum logic [1:0] {
    MODE_SYS  = 2'b00,
    MODE_CHAN = 2'b01,
    MODE_DATA = 2'b10,
    MODE_RSV  = 2'b11
  } mode_e;

  typedef struct packed {
    logic twos;
    logic sstby;
    logic pd;
  } sysctl_t;
endpackage

// File: rtl/dacdec_decode.sv
module dacdec_decode
  import dacdec_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [WORD_W-1:0]     word,
  output logic                  sys_we,
  output logic [NCH-1:0]        chan_we,
  output logic [NCH-1:0]        main_we,
  output logic [NCH-1:0]        sub_we,
  output logic [DATA_W-1:0]     payload,
  output logic                  bad
);
  mode_e             mode;
  logic [ADDR_W-1:0] addr;
  logic              addr_ok;
  logic              sel_sub;

  always_comb begin
    mode    = mode_e'(word[MODE_LSB +: 2]);
    addr    = word[ADDR_LSB +: ADDR_W];
    sel_sub = word[SEL_BIT];
    payload = word[DATA_W-1:0];
    addr_ok = (32'(addr) < NCH);
  end

  always_comb begin
    sys_we = wr_en && (mode == MODE_SYS);
    bad    = wr_en && ((mode == MODE_RSV) ||
                       (((mode == MODE_CHAN) || (mode == MODE_DATA)) && !addr_ok));
  end

  for (genvar i = 0; i < NCH; i++) begin : g_sel
    logic hit;
    always_comb begin
      hit        = wr_en && (addr == ADDR_W'(i));
      chan_we[i] = hit && (mode == MODE_CHAN);
      main_we[i] = hit && (mode == MODE_DATA) && !sel_sub;
      sub_we[i]  = hit && (mode == MODE_DATA) && sel_sub;
    end
  end

  AST_SEL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sys_we, (|chan_we), (|main_we), (|sub_we), bad})); // R1
  AST_BAD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    bad |-> (chan_we == '0) && (main_we == '0) && (sub_we == '0)); // R8
endmodule

// File: rtl/dacdec_sysreg.sv
module dacdec_sysreg
  import dacdec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [2:0] din,
  output sysctl_t    sys_q
);
  sysctl_t sys_d;

  always_comb begin
    sys_d = sys_q;
    if (we) sys_d = sysctl_t'(din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_q.pd    <= 1'b1;
      sys_q.sstby <= 1'b1;
      sys_q.twos  <= 1'b0;
    end else begin
      sys_q <= sys_d;
    end
  end

  AST_SYS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(sys_q)); // R5
endmodule

// File: rtl/dacdec_channel.sv
module dacdec_channel #(
  parameter int MW = 10,
  parameter int SW = 8,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_we,
  input  logic          main_we,
  input  logic          sub_we,
  input  logic [MW-1:0] payload,
  input  logic          load,
  input  logic          clear_n,
  input  logic          twos,
  output logic [CW-1:0] ctrl_q,
  output logic [MW-1:0] main_dac_q,
  output logic [SW-1:0] sub_dac_q
);
  localparam logic [MW-1:0] MAIN_MID = MW'(1) << (MW - 1);
  localparam logic [SW-1:0] SUB_MID  = SW'(1) << (SW - 1);

  logic [CW-1:0] ctrl_d;
  logic [MW-1:0] main_dat_q, main_dat_d, main_dac_d;
  logic [SW-1:0] sub_dat_q, sub_dat_d, sub_dac_d;
  logic [MW-1:0] main_clr;
  logic [SW-1:0] sub_clr;

  always_comb begin
    main_clr = twos ? '0 : MAIN_MID;
    sub_clr  = twos ? '0 : SUB_MID;
  end

  always_comb begin
    ctrl_d     = ctrl_q;
    main_dat_d = main_dat_q;
    sub_dat_d  = sub_dat_q;
    if (ctrl_we) ctrl_d     = payload[CW-1:0];
    if (main_we) main_dat_d = payload;
    if (sub_we)  sub_dat_d  = payload[MW-1 -: SW];
  end

  always_comb begin
    main_dac_d = main_dac_q;
    sub_dac_d  = sub_dac_q;
    if (!clear_n) begin
      main_dac_d = main_clr;
      sub_dac_d  = sub_clr;
    end else if (load) begin
      main_dac_d = main_dat_q;
      sub_dac_d  = sub_dat_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      main_dat_q <= MAIN_MID;
      sub_dat_q  <= SUB_MID;
      main_dac_q <= MAIN_MID;
      sub_dac_q  <= SUB_MID;
    end else begin
      ctrl_q     <= ctrl_d;
      main_dat_q <= main_dat_d;
      sub_dat_q  <= sub_dat_d;
      main_dac_q <= main_dac_d;
      sub_dac_q  <= sub_dac_d;
    end
  end

  AST_CLR_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_n |=> main_dac_q == ($past(twos) ? '0 : MAIN_MID)); // R7
  AST_CLR_SUB: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_n |=> sub_dac_q == ($past(twos) ? '0 : SUB_MID)); // R7
  AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && load) |=> (main_dac_q == $past(main_dat_q)) && (sub_dac_q == $past(sub_dat_q))); // R6
  AST_DAC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && !load) |=> $stable(main_dac_q) && $stable(sub_dac_q)); // R6
endmodule

// File: rtl/dacdec_top.sv
module dacdec_top
  import dacdec_pkg::*;
#(
  parameter int NCH = 4,
  parameter int MW  = 10,
  parameter int SW  = 8,
  parameter int CW  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [15:0]       word_i,
  input  logic              load_i,
  input  logic              clear_n_i,
  output logic [2:0]        sys_ctrl_o,
  output logic [NCH*CW-1:0] chan_ctrl_o,
  output logic [NCH*MW-1:0] main_dac_o,
  output logic [NCH*SW-1:0] sub_dac_o,
  output logic              err_o
);
  logic              sys_we, bad;
  logic [NCH-1:0]    chan_we, main_we, sub_we;
  logic [DATA_W-1:0] payload;
  sysctl_t           sys_q;
  logic              err_q, err_d;

  dacdec_decode #(.NCH(NCH)) u_decode (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .word(word_i),
    .sys_we(sys_we), .chan_we(chan_we), .main_we(main_we), .sub_we(sub_we),
    .payload(payload), .bad(bad)
  );

  dacdec_sysreg u_sysreg (
    .clk(clk), .rst_n(rst_n), .we(sys_we), .din(payload[2:0]), .sys_q(sys_q)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dacdec_channel #(.MW(MW), .SW(SW), .CW(CW)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .ctrl_we(chan_we[i]), .main_we(main_we[i]), .sub_we(sub_we[i]),
      .payload(payload[MW-1:0]), .load(load_i), .clear_n(clear_n_i),
      .twos(sys_q.twos),
      .ctrl_q(chan_ctrl_o[i*CW +: CW]),
      .main_dac_q(main_dac_o[i*MW +: MW]),
      .sub_dac_q(sub_dac_o[i*SW +: SW])
    );
  end

  always_comb begin
    err_d      = bad;
    sys_ctrl_o = sys_q;
    err_o      = err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  AST_ERR_SYS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $stable(sys_q)); // R8
  AST_ERR_CTRL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $stable(chan_ctrl_o)); // R8
endmodule

// File: tb/dacdec_top_bench.sv
module dacdec_top_bench;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en_i, load_i, clear_n_i;
  logic [15:0] word_i;
  logic [2:0] sys_ctrl_o;
  logic [NCH*4-1:0] chan_ctrl_o;
  logic [NCH*10-1:0] main_dac_o;
  logic [NCH*8-1:0] sub_dac_o;
  logic err_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [2:0] e_sys;
  logic [3:0] e_ctrl[NCH];
  logic [9:0] e_mdat[NCH], e_mdac[NCH];
  logic [7:0] e_sdat[NCH], e_sdac[NCH];

  always #2.5 clk = ~clk;

  dacdec_top u_dacdec_top (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .word_i(word_i),
    .load_i(load_i), .clear_n_i(clear_n_i), .sys_ctrl_o(sys_ctrl_o),
    .chan_ctrl_o(chan_ctrl_o), .main_dac_o(main_dac_o), .sub_dac_o(sub_dac_o),
    .err_o(err_o)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(string tag, logic e_err);
    chk(tag, "sys_ctrl", 32'(sys_ctrl_o), 32'(e_sys));
    chk(tag, "err", 32'(err_o), 32'(e_err));
    for (int i = 0; i < NCH; i++) begin
      chk(tag, "chan_ctrl", 32'(chan_ctrl_o[i*4 +: 4]), 32'(e_ctrl[i]));
      chk(tag, "main_dac", 32'(main_dac_o[i*10 +: 10]), 32'(e_mdac[i]));
      chk(tag, "sub_dac", 32'(sub_dac_o[i*8 +: 8]), 32'(e_sdac[i]));
    end
  endtask

  function automatic logic [15:0] mk(bit s, int a, int m, int d);
    return {s, 3'(a), 2'(m), 10'(d)};
  endfunction

  // one word; updates the model; returns expected error flag
  task automatic put(logic [15:0] w, output logic e_err);
    int a, m;
    a = int'(w[14:12]);
    m = int'(w[11:10]);
    e_err = 1'b0;
    if (m == 0) e_sys = w[2:0];
    else if (m == 3 || a >= NCH) e_err = 1'b1;
    else if (m == 1) e_ctrl[a] = w[3:0];
    else if (w[15]) e_sdat[a] = w[9:2];
    else e_mdat[a] = w[9:0];
    @(negedge clk); wr_en_i = 1'b1; word_i = w;
    @(negedge clk); wr_en_i = 1'b0; word_i = '0;
  endtask

  task automatic do_load();
    for (int i = 0; i < NCH; i++) begin
      e_mdac[i] = e_mdat[i];
      e_sdac[i] = e_sdat[i];
    end
    @(negedge clk); load_i = 1'b1;
    @(negedge clk); load_i = 1'b0;
  endtask

  task automatic do_clear(bit with_load);
    for (int i = 0; i < NCH; i++) begin
      e_mdac[i] = e_sys[2] ? 10'h000 : 10'h200;
      e_sdac[i] = e_sys[2] ? 8'h00 : 8'h80;
    end
    @(negedge clk); clear_n_i = 1'b0; load_i = with_load;
    @(negedge clk); clear_n_i = 1'b1; load_i = 1'b0;
  endtask

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic ee;
    rst_n = 1'b0; wr_en_i = 1'b0; load_i = 1'b0; clear_n_i = 1'b1; word_i = '0;
    e_sys = 3'b011;
    for (int i = 0; i < NCH; i++) begin
      e_ctrl[i] = '0; e_mdat[i] = 10'h200; e_mdac[i] = 10'h200;
      e_sdat[i] = 8'h80; e_sdac[i] = 8'h80;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R4", 1'b0);

    // R1 R5: system control with assorted address fields
    for (int v = 0; v < 8; v++) begin
      put(mk(v[0], v, 0, v), ee);
      chk_all("R5", ee);
    end
    put(mk(0, 0, 0, 0), ee);
    chk_all("R5", ee);

    // R1 R5: channel control per channel
    for (int c = 0; c < NCH; c++) begin
      put(mk(0, c, 1, 10'h3F0 | (c * 3 + 1)), ee);
      chk_all("R5", ee);
    end

    // R2 R3 R6: sweep data values on every channel
    for (int v = 0; v < 1024; v += 31) begin
      for (int c = 0; c < NCH; c++) begin
        put(mk(0, c, 2, (v + c * 101) & 10'h3FF), ee);
        put(mk(1, c, 2, (v ^ (c * 77)) & 10'h3FF), ee);
      end
      chk_all("R6", 1'b0);
      do_load();
      chk_all("R2", 1'b0);
    end
    for (int c = 0; c < NCH; c++) begin
      put(mk(0, c, 2, 10'h3FF), ee);
      put(mk(1, c, 2, 10'h003), ee);
    end
    do_load();
    chk_all("R3", 1'b0);

    // R8: sweep every select/address/mode combination
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 8; a++)
        for (int m = 0; m < 4; m++) begin
          put(mk(s[0], a, m, 10'h155 + a * 5 + m), ee);
          chk_all("R8", ee);
          @(negedge clk);
          chk_all("R8", 1'b0);
          do_load();
          chk_all("R1", 1'b0);
        end

    // R6: write and load in the same cycle uses old data
    put(mk(0, 1, 2, 10'h111), ee);
    do_load();
    e_mdat[2] = 10'h2EE;
    e_mdac[2] = e_mdat[2];
    e_mdat[2] = 10'h0AA;
    @(negedge clk); wr_en_i = 1'b0; word_i = mk(0, 2, 2, 10'h2EE); wr_en_i = 1'b1;
    @(negedge clk); word_i = mk(0, 2, 2, 10'h0AA); load_i = 1'b1;
    @(negedge clk); wr_en_i = 1'b0; load_i = 1'b0;
    chk_all("R6", 1'b0);
    do_load();
    chk_all("R6", 1'b0);

    // R7: clear under both codings, with and without load
    put(mk(0, 0, 0, 3'b000), ee);
    do_clear(1'b0);
    chk_all("R7", 1'b0);
    do_load();
    chk_all("R7", 1'b0);
    put(mk(0, 0, 0, 3'b100), ee);
    do_clear(1'b1);
    chk_all("R7", 1'b0);
    do_load();
    chk_all("R7", 1'b0);
    put(mk(0, 5, 0, 3'b010), ee);
    do_clear(1'b1);
    chk_all("R7", 1'b0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule